// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Rate Trim

This block keeps a running time of day for precision time protocol work. It holds a 32-bit seconds count and a 32-bit nanoseconds count. On every clock edge the nanoseconds advance by a fixed nominal step, which is 8 ns by default. A signed fractional correction, programmed by software, adds or removes a single nanosecond now and then. This lets the local clock be pulled faster or slower in units of parts per billion. When the nanoseconds pass 999,999,999 they wrap, and the seconds count goes up by one. That rollover can raise a once-per-second interrupt pulse.

Software reaches the block through a simple register port. A read of the latch address takes a coherent snapshot of both time words. The nanoseconds and seconds addresses then return that snapshot. Software sets the time by writing the nanoseconds word first and the seconds word second. The write of the seconds word loads both words into the counter on the same edge. A step adjustment is a read of the time, the addition of an offset, and a write of the result. Software does all three steps under one lock.

The trim word is in sign-magnitude form. Bit 31 is the sign, and a set sign slows the clock. Bits 30:0 hold the magnitude, where one unit is 2^-32 ns per clock. With an 8 ns step, a rate of P parts per billion gives a magnitude of (P << 26) / 1,953,125. The largest supported rate is 62,499,999 ppb.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the snapshot nanoseconds (address 1) and snapshot seconds (address 2) read 0. The trim word (address 3) and the interrupt enable (address 4) read 0, and `sec_wrap_irq` is low.
- R2: With a zero trim magnitude, the live nanoseconds go up by STEP_NS (8) on every clock edge.
- R3: A write to address 2 loads the written seconds and the staged nanoseconds into the live time on that edge. It also clears the fractional accumulator. A latch read on the next edge returns exactly the written pair.
- R4: When nanoseconds plus the step reach 1,000,000,000, the nanoseconds take the excess and the seconds go up by one. This also holds while a trim is active.
- R5: A read with `reg_rd` high at address 0 captures the live time on that edge. Addresses 1 and 2 keep returning that capture until the next latch read.
- R6: With bit 31 of the trim word clear and magnitude M, k edges after a commit the time has gained exactly floor(k·M / 2^32) ns over k·STEP_NS.
- R7: With bit 31 set and magnitude M, k edges after a commit the time has lost exactly ceil(k·M / 2^32) ns against k·STEP_NS.
- R8: While bit 0 of address 4 is set, `sec_wrap_irq` is high for exactly one clock in the cycle the seconds roll over. It stays low while that bit is clear, and a software write of the seconds never raises it.
- R9: A write to address 3 can be read back unchanged at address 3. The write also clears the fractional accumulator.
- R10: A write to address 1 alone does not change the running time. The value waits until a write to address 2 commits it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time base clock; one STEP_NS per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; at address 0 it takes the snapshot |
| reg_addr | input | 3 | Register address (0 latch, 1 nanoseconds, 2 seconds, 3 trim, 4 interrupt enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sec_wrap_irq | output | 1 | One-clock pulse on a seconds rollover when enabled |

## Verification
The assertions assume that software never stages a nanoseconds value of 1,000,000,000 or more. They also assume a trim magnitude small enough that a single clock moves the time by no more than one nanosecond above or below the nominal step. If either assumption is broken, the range and step-size properties would fail. The stimulus draws nanoseconds with `$urandom_range` below one billion. It derives each trim magnitude from a rate at or under 62,499,999 ppb using the same shift-and-divide rule as software. It also places all trim writes before the commit that starts a checked window, so the predicted fraction always starts from zero.

// File: rtl/ptp_tod_pkg.sv
// Shared constants for the time-of-day counter: register addresses,
// word width and the nanosecond rollover limit.
package ptp_tod_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned TRIM_W   = 31;
    localparam logic [WORD_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

    localparam logic [ADDR_W-1:0] A_LATCH = 3'd0;
    localparam logic [ADDR_W-1:0] A_NS    = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEC   = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIM  = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQEN = 3'd4;
endpackage

// File: rtl/ptp_rate_trim.sv
// Fractional rate trim. Accumulates a sign-magnitude correction in a
// FRAC_W-bit fraction (unit 2^-FRAC_W ns) and turns each carry or borrow
// into one extra or one missing nanosecond for this clock's step.
// Assumes FRAC_W >= TRIM_W so the magnitude fits the accumulator.
module ptp_rate_trim #(
    parameter int unsigned STEP_NS = 8,
    parameter int unsigned FRAC_W  = 32,
    parameter int unsigned STEP_W  = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                trim_neg,
    input  logic [ptp_tod_pkg::TRIM_W-1:0]      trim_mag,
    output logic [STEP_W-1:0]                   step
);
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   acc;
    logic [FRAC_W:0]   mag_ext;
    logic              ovf;

    // Next fraction and the carry or borrow it produces.
    always_comb begin
        mag_ext = (FRAC_W+1)'(trim_mag);
        if (trim_neg) acc = {1'b0, frac_q} - mag_ext;
        else          acc = {1'b0, frac_q} + mag_ext;
        ovf = acc[FRAC_W];
    end

    // Nanosecond step for this edge: nominal, one more, or one less.
    always_comb begin
        if (trim_neg) step = STEP_W'(STEP_NS) - STEP_W'(ovf);
        else          step = STEP_W'(STEP_NS) + STEP_W'(ovf);
    end

    // Fraction register, cleared on reset, on trim writes and on time loads.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) frac_q <= '0;
        else                 frac_q <= acc[FRAC_W-1:0];
    end
endmodule

// File: rtl/ptp_tod_counter.sv
// Live seconds/nanoseconds counter. Adds the per-edge step, wraps the
// nanoseconds at one billion with a carry into seconds, and loads both
// words at once on a commit. Assumes step is far below one billion.
module ptp_tod_counter #(
    parameter int unsigned STEP_W = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [ptp_tod_pkg::WORD_W-1:0]     load_sec,
    input  logic [ptp_tod_pkg::WORD_W-1:0]     load_ns,
    input  logic [STEP_W-1:0]                  step,
    output logic [ptp_tod_pkg::WORD_W-1:0]     tod_sec,
    output logic [ptp_tod_pkg::WORD_W-1:0]     tod_ns,
    output logic                               wrap_pulse
);
    import ptp_tod_pkg::*;

    logic [WORD_W:0] ns_sum;
    logic            wrap;

    // Sum of the current nanoseconds and the step, and the rollover test.
    always_comb begin
        ns_sum = {1'b0, tod_ns} + (WORD_W+1)'(step);
        wrap   = (ns_sum >= {1'b0, NS_PER_SEC});
    end

    // Time registers: a load wins over advancing; a rollover carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_sec    <= '0;
            tod_ns     <= '0;
            wrap_pulse <= 1'b0;
        end else if (load) begin
            tod_sec    <= load_sec;
            tod_ns     <= load_ns;
            wrap_pulse <= 1'b0;
        end else if (wrap) begin
            tod_sec    <= tod_sec + 1'b1;
            tod_ns     <= WORD_W'(ns_sum - {1'b0, NS_PER_SEC});
            wrap_pulse <= 1'b1;
        end else begin
            tod_ns     <= ns_sum[WORD_W-1:0];
            wrap_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/ptp_tod_regs.sv
// Register port: snapshot on a latch read, staged nanoseconds committed
// by the seconds write, sign-magnitude trim word and interrupt enable.
// Assumes one access per clock; read data is a pure address decode.
module ptp_tod_regs (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic                               reg_rd,
    input  logic [ptp_tod_pkg::ADDR_W-1:0]     reg_addr,
    input  logic [ptp_tod_pkg::WORD_W-1:0]     reg_wdata,
    output logic [ptp_tod_pkg::WORD_W-1:0]     reg_rdata,
    input  logic [ptp_tod_pkg::WORD_W-1:0]     live_sec,
    input  logic [ptp_tod_pkg::WORD_W-1:0]     live_ns,
    output logic                               commit,
    output logic [ptp_tod_pkg::WORD_W-1:0]     commit_ns,
    output logic                               trim_neg,
    output logic [ptp_tod_pkg::TRIM_W-1:0]     trim_mag,
    output logic                               trim_clear,
    output logic                               irq_en
);
    import ptp_tod_pkg::*;

    logic [WORD_W-1:0] snap_sec, snap_ns;
    logic              trim_wr;

    // Write strobes decoded from the address.
    always_comb begin
        commit     = reg_wr && (reg_addr == A_SEC);
        trim_wr    = reg_wr && (reg_addr == A_TRIM);
        trim_clear = commit || trim_wr;
    end

    // Snapshot pair, captured together on a latch read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_sec <= '0;
            snap_ns  <= '0;
        end else if (reg_rd && (reg_addr == A_LATCH)) begin
            snap_sec <= live_sec;
            snap_ns  <= live_ns;
        end
    end

    // Staged nanoseconds, trim word and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_ns <= '0;
            trim_neg  <= 1'b0;
            trim_mag  <= '0;
            irq_en    <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_NS)    commit_ns <= reg_wdata;
            if (reg_addr == A_TRIM)  {trim_neg, trim_mag} <= reg_wdata;
            if (reg_addr == A_IRQEN) irq_en <= reg_wdata[0];
        end
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            A_NS:    reg_rdata = snap_ns;
            A_SEC:   reg_rdata = snap_sec;
            A_TRIM:  reg_rdata = {trim_neg, trim_mag};
            A_IRQEN: reg_rdata = {{(WORD_W-1){1'b0}}, irq_en};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptp_tod_clock.sv
// Top of the time-of-day counter with rate trim. Wires the register
// port, the fractional trim and the live counter, and gates the
// seconds-rollover pulse with the interrupt enable.
module ptp_tod_clock #(
    parameter int unsigned STEP_NS = 8,
    parameter int unsigned FRAC_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sec_wrap_irq
);
    import ptp_tod_pkg::*;

    localparam int unsigned STEP_W = $clog2(STEP_NS + 2) + 1;

    logic              commit, trim_clear, trim_neg, irq_en, wrap_q;
    logic [WORD_W-1:0] commit_ns, tod_sec, tod_ns;
    logic [TRIM_W-1:0] trim_mag;
    logic [STEP_W-1:0] step;

    ptp_tod_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .live_sec(tod_sec), .live_ns(tod_ns), .commit(commit),
        .commit_ns(commit_ns), .trim_neg(trim_neg), .trim_mag(trim_mag),
        .trim_clear(trim_clear), .irq_en(irq_en)
    );

    ptp_rate_trim #(.STEP_NS(STEP_NS), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_trim (
        .clk(clk), .rst_n(rst_n), .clear(trim_clear),
        .trim_neg(trim_neg), .trim_mag(trim_mag), .step(step)
    );

    ptp_tod_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(commit), .load_sec(reg_wdata),
        .load_ns(commit_ns), .step(step), .tod_sec(tod_sec),
        .tod_ns(tod_ns), .wrap_pulse(wrap_q)
    );

    // Rollover interrupt, gated by the software enable.
    assign sec_wrap_irq = wrap_q && irq_en;
endmodule

// File: rtl/ptp_tod_checker.sv
// Assertion checker for ptp_tod_clock, attached by bind.
// Assumes staged nanoseconds stay below one billion and the trim moves
// each step by at most one nanosecond.
module ptp_tod_checker #(
    parameter int unsigned STEP_NS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        commit,
    input logic [31:0] wdata,
    input logic [31:0] staged_ns,
    input logic [31:0] tod_sec,
    input logic [31:0] tod_ns,
    input logic        irq
);
    // R4: nanoseconds never reach one billion.
    a_r4_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tod_ns < 32'd1_000_000_000);

    // R3: a seconds write loads both words on the same edge.
    a_r3_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (tod_sec == $past(wdata)) && (tod_ns == $past(staged_ns)));

    // R4: without a load, seconds hold or go up by exactly one.
    a_r4_sec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (tod_sec == $past(tod_sec)) || (tod_sec == $past(tod_sec) + 32'd1));

    // R2: each advance is the nominal step within one nanosecond.
    a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (tod_sec == $past(tod_sec))
            ? ((tod_ns - $past(tod_ns) >= 32'(STEP_NS - 1)) &&
               (tod_ns - $past(tod_ns) <= 32'(STEP_NS + 1)))
            : (tod_ns <= 32'(STEP_NS)));

    // R8: the interrupt shows only in the cycle the seconds went up by one.
    a_r8_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tod_sec == $past(tod_sec) + 32'd1));

    // R8: the interrupt lasts a single clock.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind ptp_tod_clock ptp_tod_checker #(.STEP_NS(STEP_NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wdata(reg_wdata),
    .staged_ns(commit_ns), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .irq(sec_wrap_irq)
);

// File: tb/tb_ptp_tod_clock.sv
module tb_ptp_tod_clock;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned BIL = 64'd1_000_000_000;
    localparam int STEP = 8;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        sec_wrap_irq;

    int errors = 0, checks = 0;
    longint unsigned cyc = 0, last_edge = 0, commit_edge = 0;
    longint unsigned base_s = 0, base_n = 0, trim_m = 0;
    bit trim_n = 1'b0;
    int irq_cnt = 0;

    ptp_tod_clock dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sec_wrap_irq(sec_wrap_irq));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && sec_wrap_irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1; last_edge = cyc; reg_wr = 1'b0;
    endtask

    task automatic latch();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd0;
        @(posedge clk); #1; last_edge = cyc; reg_rd = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic set_trim(input bit neg, input longint unsigned mag);
        trim_n = neg; trim_m = mag;
        wr(3'd3, {neg, mag[30:0]});
    endtask

    task automatic set_time(input longint unsigned s, input longint unsigned n);
        wr(3'd1, n[31:0]); wr(3'd2, s[31:0]);
        commit_edge = last_edge; base_s = s; base_n = n;
    endtask

    // Expected total nanoseconds k advancing edges after the commit.
    function automatic longint unsigned exp_total(input longint unsigned k);
        longint unsigned prod, tot;
        prod = k * trim_m;
        tot = base_s * BIL + base_n + k * STEP;
        if (trim_n) tot = tot - ((prod + 64'hFFFF_FFFF) >> 32);
        else        tot = tot + (prod >> 32);
        return tot;
    endfunction

    task automatic check_time(input string req);
        logic [31:0] s, n;
        longint unsigned t;
        latch();
        t = exp_total(last_edge - commit_edge - 1);
        rd(3'd1, n); rd(3'd2, s);
        chk(n == 32'(t % BIL), {req, " ns"}, n, t % BIL);
        chk(s == 32'(t / BIL), {req, " sec"}, s, t / BIL);
    endtask

    function automatic longint unsigned ppb_to_mag(input longint unsigned ppb);
        return (ppb << 26) / 64'd1_953_125;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int c0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        rd(3'd1, v); chk(v == 0, "R1 snap ns", v, 0);
        rd(3'd2, v); chk(v == 0, "R1 snap sec", v, 0);
        rd(3'd3, v); chk(v == 0, "R1 trim", v, 0);
        rd(3'd4, v); chk(v == 0, "R1 irq enable", v, 0);
        chk(sec_wrap_irq == 0, "R1 irq", sec_wrap_irq, 0);
        @(negedge clk); rst_n = 1'b1;

        // R3: commit then immediate latch returns the written pair
        set_time(64'd5, 64'd100);
        check_time("R3 commit");
        // R2: nominal advance
        repeat (37) @(posedge clk);
        check_time("R2 nominal");
        // R10: staging nanoseconds alone leaves the time running untouched
        wr(3'd1, 32'd123);
        check_time("R10 staged only");
        // R5: snapshot holds while time runs
        rd(3'd1, v); repeat (50) @(posedge clk); #1; rd(3'd1, v2);
        chk(v == v2, "R5 snapshot held", v2, v);
        // R9: trim readback
        set_trim(1'b1, 64'h7FFF_FFFF);
        rd(3'd3, v); chk(v == 32'hFFFF_FFFF, "R9 trim readback", v, 32'hFFFF_FFFF);
        // R7: largest negative magnitude
        set_time(64'd9, 64'd500);
        repeat (4) @(posedge clk);
        check_time("R7 slow max");
        // R4: rollover under negative trim
        set_time(64'd7, 64'd999_999_990);
        repeat (5) @(posedge clk);
        check_time("R4 wrap slow");
        // R6 and R4: rollover under positive trim
        set_trim(1'b0, ppb_to_mag(64'd62_499_999));
        set_time(64'd7, 64'd999_999_950);
        repeat (20) @(posedge clk);
        check_time("R6 R4 wrap fast");

        // R8: interrupt enabled, exactly one pulse
        set_trim(1'b0, 64'd0);
        wr(3'd4, 32'd1);
        c0 = irq_cnt;
        set_time(64'd20, 64'd999_999_976);
        repeat (10) @(posedge clk); #1;
        chk(irq_cnt - c0 == 1, "R8 one pulse", irq_cnt - c0, 1);
        // R8: software seconds write raises nothing
        c0 = irq_cnt;
        set_time(64'd40, 64'd1000);
        repeat (10) @(posedge clk); #1;
        chk(irq_cnt - c0 == 0, "R8 write no pulse", irq_cnt - c0, 0);
        // R8: disabled
        wr(3'd4, 32'd0);
        c0 = irq_cnt;
        set_time(64'd21, 64'd999_999_976);
        repeat (10) @(posedge clk); #1;
        chk(irq_cnt - c0 == 0, "R8 disabled", irq_cnt - c0, 0);
        check_time("R4 wrap after irq test");

        // Random rates, times and waits (R6, R7, R4)
        for (int i = 0; i < 24; i++) begin
            bit neg;
            longint unsigned ppb, s, n;
            neg = $urandom_range(0, 1);
            ppb = $urandom_range(0, 62_499_999);
            s = $urandom_range(0, 32'h7FFF_FFFF);
            n = (i % 4 == 0) ? (BIL - 64'($urandom_range(1, 400))) : 64'($urandom_range(0, 999_999_999));
            set_trim(neg, ppb_to_mag(ppb));
            set_time(s, n);
            repeat ($urandom_range(0, 3000)) @(posedge clk);
            check_time(neg ? "R7 random" : "R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule